// File: doc/BRIEF.md
# I2C Dual-Role Operating Mode Tracker

This block keeps track of which of four roles an I2C port that can both drive and answer the bus is playing at any moment. The four roles are slave-receive, slave-transmit, master-transmit and master-receive. It resynchronises the raw SDA and SCL samples and finds START and STOP conditions on them. It keeps a bus-busy flag. Each time a slave address phase opens, it decides whether the incoming address byte is meant for this port.

When nothing is happening, the port rests in slave-receive so that it hears every address on the bus. A matching address with the direction bit clear leaves it in slave-receive. A matching address with the direction bit set moves it to slave-transmit. A match means either the programmed own address or, when enabled, the general call address.

Local requests can open a transaction while the bus is free. The port then enters master-transmit to send the address, and switches to master-receive only once the address phase of a read completes. The same requests can issue a repeated START, a STOP or one more byte. Each accepted request leaves as a single-cycle command pulse toward the byte engine. Byte shifting, clock stretching and arbitration are handled elsewhere. The assembled address byte arrives with a strobe.

Top module: `dual_role_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode is slave-receive (mode code 2'b00) and bus_busy, start_det, stop_det, addr_hit, gc_hit, cmd_start, cmd_stop and cmd_byte are all 0.
- R2: An SDA fall while SCL is high gives exactly one single-cycle start_det pulse, three clock edges after the change is sampled, and bus_busy rises with it. An SDA fall while SCL is low gives no pulse.
- R3: An SDA rise while SCL is high gives exactly one single-cycle stop_det pulse, clears bus_busy, and on the next edge returns the mode to slave-receive with addr_hit and gc_hit cleared.
- R4: The first address strobe after a START matches when addr_byte[7:1] equals own_addr. Bit 0 is the direction bit: 0 keeps slave-receive (2'b00) with addr_hit=1, and 1 selects slave-transmit (2'b01) with addr_hit=1.
- R5: The address byte with bits [7:1] all zero matches as a general call only while gc_en is 1, and it then sets both addr_hit and gc_hit. With gc_en at 0 it matches nothing (unless own_addr is zero).
- R6: A non-matching address leaves slave-receive with addr_hit=0. Further address strobes after the first one following a START are ignored. A START seen in a slave mode returns to slave-receive and clears the match flags.
- R7: A start request is accepted only in slave-receive while bus_busy is 0. It then moves the mode to master-transmit (2'b10) with a cmd_start pulse. Otherwise it is refused with no pulse.
- R8: addr_done during the address phase moves a read transaction to master-receive (2'b11) and leaves a write in master-transmit.
- R9: A repeated-START request in either master mode gives a cmd_start pulse, re-enters master-transmit and opens a new address phase with the direction given by req_rd.
- R10: In a master mode, req_stop gives a cmd_stop pulse, and req_byte gives a cmd_byte pulse only once the address phase is over. Neither request gives a pulse in a slave mode.
- R11: When a detected STOP meets any request or addr_done in the same cycle, the STOP wins: the mode goes to slave-receive and no command pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Raw SDA line sample |
| scl_in | input | 1 | Raw SCL line sample |
| own_addr | input | 7 | Programmed own slave address |
| gc_en | input | 1 | Enables the general call match |
| addr_byte | input | 8 | Received address byte, direction in bit 0 |
| addr_valid | input | 1 | Strobe for addr_byte |
| req_start | input | 1 | Request to open a master transaction |
| req_restart | input | 1 | Request for a repeated START |
| req_rd | input | 1 | Direction of the requested transaction, 1 = read |
| req_stop | input | 1 | Request to end the transaction |
| req_byte | input | 1 | Request for one more byte transfer |
| addr_done | input | 1 | Master address byte has been sent |
| mode | output | 2 | 00 slave-rx, 01 slave-tx, 10 master-tx, 11 master-rx |
| bus_busy | output | 1 | Bus is between START and STOP |
| start_det | output | 1 | One-cycle START pulse |
| stop_det | output | 1 | One-cycle STOP pulse |
| addr_hit | output | 1 | Last address phase matched |
| gc_hit | output | 1 | The match was a general call |
| cmd_start | output | 1 | Issue a START or repeated START |
| cmd_stop | output | 1 | Issue a STOP |
| cmd_byte | output | 1 | Transfer one more byte |

## Verification
The overlap that matters is a detected STOP meeting a local request or an address completion in the same cycle. The bench raises SDA, counts the synchroniser and detector edges, and drives addr_done, or a start request, in exactly the cycle in which stop_det is high. It first confirms that stop_det is indeed high at that sample. The result is judged by the mode after the next edge: slave-receive with no command pulse. On the following cycle it judges whether a retried start request is accepted once bus_busy has fallen.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;

    localparam int ADDR_W = 7;

    typedef enum logic [1:0] {
        MODE_SLV_RX = 2'b00,
        MODE_SLV_TX = 2'b01,
        MODE_MST_TX = 2'b10,
        MODE_MST_RX = 2'b11
    } mode_e;

    typedef struct packed {
        logic sda;
        logic scl;
    } line_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic busy;
    } bus_evt_t;

    typedef struct packed {
        logic hit;
        logic gc;
        logic rw;
    } match_t;

    typedef struct packed {
        logic start;
        logic restart;
        logic rd;
        logic stop;
        logic nbyte;
        logic addr_done;
    } req_t;

    function automatic logic is_master(mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_mode_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  line_t raw,
    output line_t synced
);
    localparam int LAST = STAGES - 1;

    line_t pipe [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= '{sda: 1'b1, scl: 1'b1};
                    else     pipe[i] <= raw;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= '{sda: 1'b1, scl: 1'b1};
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign synced = pipe[LAST];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
    import i2c_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  line_t    cur,
    output bus_evt_t evt
);
    line_t prev_q;
    logic  start_q, stop_q, busy_q;
    logic  start_c, stop_c;

    assign start_c = prev_q.sda & ~cur.sda & cur.scl & prev_q.scl;
    assign stop_c  = ~prev_q.sda & cur.sda & cur.scl & prev_q.scl;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '{sda: 1'b1, scl: 1'b1};
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            prev_q  <= cur;
            start_q <= start_c;
            stop_q  <= stop_c;
            if (stop_c)       busy_q <= 1'b0;
            else if (start_c) busy_q <= 1'b1;
        end
    end

    assign evt = '{start: start_q, stop: stop_q, busy: busy_q};
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_mode_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] own_addr,
    input  logic          gc_en,
    input  logic [AW:0]   addr_byte,
    output match_t        result
);
    localparam logic [AW-1:0] GC_ADDR = '0;

    logic own_eq, gc_eq;

    assign own_eq = (addr_byte[AW:1] == own_addr);
    assign gc_eq  = gc_en & (addr_byte[AW:1] == GC_ADDR);

    assign result = '{hit: own_eq | gc_eq, gc: gc_eq, rw: addr_byte[0]};
endmodule

// File: rtl/i2c_mode_fsm.sv
module i2c_mode_fsm
    import i2c_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  match_t   am,
    input  logic     addr_valid,
    input  req_t     req,
    output mode_e    mode,
    output logic     addr_hit,
    output logic     gc_hit,
    output logic     cmd_start,
    output logic     cmd_stop,
    output logic     cmd_byte
);
    mode_e mode_q, mode_n;
    logic  expect_q, expect_n;
    logic  aphase_q, aphase_n;
    logic  rd_q, rd_n;
    logic  hit_q, hit_n;
    logic  gc_q, gc_n;
    logic  cs_n, cp_n, cb_n;
    logic  cs_q, cp_q, cb_q;

    always_comb begin
        mode_n   = mode_q;
        expect_n = expect_q;
        aphase_n = aphase_q;
        rd_n     = rd_q;
        hit_n    = hit_q;
        gc_n     = gc_q;
        cs_n     = 1'b0;
        cp_n     = 1'b0;
        cb_n     = 1'b0;
        if (evt.stop) begin
            mode_n   = MODE_SLV_RX;
            expect_n = 1'b0;
            aphase_n = 1'b0;
            hit_n    = 1'b0;
            gc_n     = 1'b0;
        end else if (evt.start && !is_master(mode_q)) begin
            mode_n   = MODE_SLV_RX;
            expect_n = 1'b1;
            hit_n    = 1'b0;
            gc_n     = 1'b0;
        end else begin
            unique case (mode_q)
                MODE_SLV_RX: begin
                    if (req.start && !evt.busy) begin
                        mode_n   = MODE_MST_TX;
                        rd_n     = req.rd;
                        aphase_n = 1'b1;
                        expect_n = 1'b0;
                        cs_n     = 1'b1;
                    end else if (addr_valid && expect_q) begin
                        expect_n = 1'b0;
                        hit_n    = am.hit;
                        gc_n     = am.gc;
                        mode_n   = (am.hit && am.rw) ? MODE_SLV_TX : MODE_SLV_RX;
                    end
                end
                MODE_SLV_TX: begin
                    mode_n = MODE_SLV_TX;
                end
                MODE_MST_TX, MODE_MST_RX: begin
                    if (req.restart) begin
                        mode_n   = MODE_MST_TX;
                        rd_n     = req.rd;
                        aphase_n = 1'b1;
                        cs_n     = 1'b1;
                    end else if (req.stop) begin
                        cp_n = 1'b1;
                    end else if (req.addr_done && aphase_q) begin
                        aphase_n = 1'b0;
                        mode_n   = rd_q ? MODE_MST_RX : MODE_MST_TX;
                    end else if (req.nbyte && !aphase_q) begin
                        cb_n = 1'b1;
                    end
                end
                default: mode_n = MODE_SLV_RX;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_SLV_RX;
            expect_q <= 1'b0;
            aphase_q <= 1'b0;
            rd_q     <= 1'b0;
            hit_q    <= 1'b0;
            gc_q     <= 1'b0;
            cs_q     <= 1'b0;
            cp_q     <= 1'b0;
            cb_q     <= 1'b0;
        end else begin
            mode_q   <= mode_n;
            expect_q <= expect_n;
            aphase_q <= aphase_n;
            rd_q     <= rd_n;
            hit_q    <= hit_n;
            gc_q     <= gc_n;
            cs_q     <= cs_n;
            cp_q     <= cp_n;
            cb_q     <= cb_n;
        end
    end

    assign mode      = mode_q;
    assign addr_hit  = hit_q;
    assign gc_hit    = gc_q;
    assign cmd_start = cs_q;
    assign cmd_stop  = cp_q;
    assign cmd_byte  = cb_q;
endmodule

// File: rtl/dual_role_mode_ctrl.sv
module dual_role_mode_ctrl
    import i2c_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AW          = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sda_in,
    input  logic          scl_in,
    input  logic [AW-1:0] own_addr,
    input  logic          gc_en,
    input  logic [AW:0]   addr_byte,
    input  logic          addr_valid,
    input  logic          req_start,
    input  logic          req_restart,
    input  logic          req_rd,
    input  logic          req_stop,
    input  logic          req_byte,
    input  logic          addr_done,
    output logic [1:0]    mode,
    output logic          bus_busy,
    output logic          start_det,
    output logic          stop_det,
    output logic          addr_hit,
    output logic          gc_hit,
    output logic          cmd_start,
    output logic          cmd_stop,
    output logic          cmd_byte
);
    line_t    raw_lines, sync_lines;
    bus_evt_t evt;
    match_t   am;
    req_t     req;
    mode_e    mode_w;

    assign raw_lines = '{sda: sda_in, scl: scl_in};
    assign req = '{start: req_start, restart: req_restart, rd: req_rd,
                   stop: req_stop, nbyte: req_byte, addr_done: addr_done};

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(raw_lines), .synced(sync_lines)
    );

    i2c_bus_cond u_cond (
        .clk(clk), .rst(rst), .cur(sync_lines), .evt(evt)
    );

    i2c_addr_match #(.AW(AW)) u_match (
        .own_addr(own_addr), .gc_en(gc_en), .addr_byte(addr_byte), .result(am)
    );

    i2c_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .am(am), .addr_valid(addr_valid),
        .req(req), .mode(mode_w), .addr_hit(addr_hit), .gc_hit(gc_hit),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_byte(cmd_byte)
    );

    assign mode      = mode_w;
    assign bus_busy  = evt.busy;
    assign start_det = evt.start;
    assign stop_det  = evt.stop;
endmodule

// File: rtl/dual_role_mode_chk.sv
module dual_role_mode_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       bus_busy,
    input logic       start_det,
    input logic       stop_det,
    input logic       addr_hit,
    input logic       gc_hit,
    input logic       cmd_start,
    input logic       cmd_stop,
    input logic       cmd_byte,
    input logic       addr_valid,
    input logic [7:0] addr_byte
);
    p_busy_on_start_r2: assert property (@(posedge clk) disable iff (rst)
        start_det |-> bus_busy);

    p_start_stop_apart_r2: assert property (@(posedge clk) disable iff (rst)
        !(start_det && stop_det));

    p_idle_after_stop_r3: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (mode == 2'b00 && !addr_hit && !gc_hit));

    p_free_on_stop_r3: assert property (@(posedge clk) disable iff (rst)
        stop_det |-> !bus_busy);

    p_slvtx_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && $past(mode) != 2'b01) |->
            ($past(addr_valid) && $past(addr_byte[0]) && addr_hit));

    p_gc_is_hit_r5: assert property (@(posedge clk) disable iff (rst)
        gc_hit |-> addr_hit);

    p_start_when_free_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && $past(mode) == 2'b00) |-> !$past(bus_busy));

    p_mrx_via_mtx_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && $past(mode) != 2'b11) |-> $past(mode) == 2'b10);

    p_cmd_single_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_start, cmd_stop, cmd_byte}));

    p_stop_beats_cmd_r11: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !(cmd_start || cmd_stop || cmd_byte));
endmodule

bind dual_role_mode_ctrl dual_role_mode_chk u_chk (
    .clk(clk), .rst(rst), .mode(mode), .bus_busy(bus_busy),
    .start_det(start_det), .stop_det(stop_det), .addr_hit(addr_hit),
    .gc_hit(gc_hit), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_byte(cmd_byte), .addr_valid(addr_valid), .addr_byte(addr_byte)
);

// File: tb/tb_dual_role_mode_ctrl.sv
`timescale 1ns/1ps
module tb_dual_role_mode_ctrl;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, sda_in, scl_in, gc_en, addr_valid;
    logic req_start, req_restart, req_rd, req_stop, req_byte, addr_done;
    logic [6:0] own_addr;
    logic [7:0] addr_byte;
    logic [1:0] mode;
    logic bus_busy, start_det, stop_det, addr_hit, gc_hit;
    logic cmd_start, cmd_stop, cmd_byte;

    int n_chk = 0;
    int n_bad = 0;
    int n_start = 0;
    int n_stop = 0;

    dual_role_mode_ctrl dut (
        .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in),
        .own_addr(own_addr), .gc_en(gc_en), .addr_byte(addr_byte),
        .addr_valid(addr_valid), .req_start(req_start), .req_restart(req_restart),
        .req_rd(req_rd), .req_stop(req_stop), .req_byte(req_byte),
        .addr_done(addr_done), .mode(mode), .bus_busy(bus_busy),
        .start_det(start_det), .stop_det(stop_det), .addr_hit(addr_hit),
        .gc_hit(gc_hit), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_byte(cmd_byte)
    );

    always @(negedge clk) begin
        if (start_det) n_start++;
        if (stop_det)  n_stop++;
    end

    // {own[6:0], gc_en, addr_byte[7:0], exp_mode[1:0], exp_hit, exp_gc}
    localparam int NV = 7;
    localparam logic [19:0] VEC [NV] = '{
        {7'h2A, 1'b0, 8'h54, 2'b00, 1'b1, 1'b0},   // R4 own write
        {7'h2A, 1'b0, 8'h55, 2'b01, 1'b1, 1'b0},   // R4 own read
        {7'h2A, 1'b0, 8'h56, 2'b00, 1'b0, 1'b0},   // R6 other address
        {7'h2A, 1'b1, 8'h00, 2'b00, 1'b1, 1'b1},   // R5 general call on
        {7'h2A, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0},   // R5 general call off
        {7'h11, 1'b1, 8'h23, 2'b01, 1'b1, 1'b0},   // R4 own read, gc on
        {7'h11, 1'b1, 8'h01, 2'b01, 1'b1, 1'b1}    // R5 general call read
    };

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        scl_in = 1'b0; step(3);
        sda_in = 1'b1; step(3);
        scl_in = 1'b1; step(3);
        sda_in = 1'b0; step(4);
    endtask

    task automatic bus_stop();
        scl_in = 1'b0; step(3);
        sda_in = 1'b0; step(3);
        scl_in = 1'b1; step(3);
        sda_in = 1'b1; step(4);
    endtask

    task automatic pulse_addr(logic [7:0] b);
        addr_byte = b; addr_valid = 1'b1; step();
        addr_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; sda_in = 1'b1; scl_in = 1'b1; gc_en = 1'b0;
        own_addr = 7'h2A; addr_byte = 8'h00; addr_valid = 1'b0;
        req_start = 0; req_restart = 0; req_rd = 0; req_stop = 0;
        req_byte = 0; addr_done = 0;
        step(4);
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 flags", {bus_busy, start_det, stop_det, addr_hit, gc_hit}, 0);
        chk("R1 cmds", {cmd_start, cmd_stop, cmd_byte}, 0);

        // R2 SDA fall while SCL low: no START
        scl_in = 1'b0; step(2); sda_in = 1'b0; step(5);
        chk("R2 no start scl low", n_start, 0);
        chk("R2 idle busy", bus_busy, 0);
        sda_in = 1'b1; step(2); scl_in = 1'b1; step(4);

        // R2 exact START latency: change sampled at edge 1, pulse after edge 3
        sda_in = 1'b0; step(2);
        chk("R2 start before latency", start_det, 0);
        step();
        chk("R2 start pulse", start_det, 1);
        chk("R2 busy set", bus_busy, 1);
        step();
        chk("R2 start single", start_det, 0);
        chk("R2 start count", n_start, 1);
        bus_stop();
        chk("R3 stop count", n_stop, 1);
        chk("R3 busy clear", bus_busy, 0);

        // table walk over address matching
        for (int i = 0; i < NV; i++) begin
            own_addr = VEC[i][19:13];
            gc_en    = VEC[i][12];
            bus_start();
            pulse_addr(VEC[i][11:4]);
            chk($sformatf("R4/R5/R6 vec%0d mode", i), mode, VEC[i][3:2]);
            chk($sformatf("R4/R5/R6 vec%0d hit", i), addr_hit, VEC[i][1]);
            chk($sformatf("R5 vec%0d gc", i), gc_hit, VEC[i][0]);
            bus_stop();
            chk($sformatf("R3 vec%0d back to slave-rx", i), {mode, addr_hit, gc_hit}, 0);
        end
        chk("R2 start count table", n_start, 1 + NV);

        // R6 second strobe after a miss is ignored
        own_addr = 7'h2A; gc_en = 1'b0;
        bus_start();
        pulse_addr(8'h56);
        pulse_addr(8'h55);
        chk("R6 late strobe mode", mode, 0);
        chk("R6 late strobe hit", addr_hit, 0);
        bus_stop();

        // R6 START in slave-transmit rearms the address phase
        bus_start();
        pulse_addr(8'h55);
        chk("R4 slave-tx", mode, 1);
        bus_start();
        chk("R6 restart clears mode", mode, 0);
        chk("R6 restart clears hit", addr_hit, 0);
        pulse_addr(8'h54);
        chk("R6 rearmed match", {mode, addr_hit}, 1);

        // R7 request refused while busy; R10 no commands in slave mode
        req_start = 1; req_stop = 1; req_byte = 1; step();
        req_start = 0; req_stop = 0; req_byte = 0;
        chk("R7 refused mode", mode, 0);
        chk("R7 R10 no cmds", {cmd_start, cmd_stop, cmd_byte}, 0);
        bus_stop();

        // R7 accepted while free, write transaction
        req_start = 1; req_rd = 0; step();
        req_start = 0;
        chk("R7 accepted mode", mode, 2);
        chk("R7 cmd_start", cmd_start, 1);
        // R10 byte refused in address phase
        req_byte = 1; step(); req_byte = 0;
        chk("R10 no byte in address phase", cmd_byte, 0);
        addr_done = 1; step(); addr_done = 0;
        chk("R8 write stays master-tx", mode, 2);
        req_byte = 1; step(); req_byte = 0;
        chk("R10 cmd_byte", cmd_byte, 1);
        // R9 repeated START as read
        req_restart = 1; req_rd = 1; step(); req_restart = 0; req_rd = 0;
        chk("R9 mode", mode, 2);
        chk("R9 cmd_start", cmd_start, 1);
        addr_done = 1; step(); addr_done = 0;
        chk("R8 read to master-rx", mode, 3);
        req_stop = 1; step(); req_stop = 0;
        chk("R10 cmd_stop", cmd_stop, 1);
        chk("R10 still master", mode, 3);
        bus_start();
        chk("R6 own START ignored in master", mode, 3);
        bus_stop();
        chk("R3 master to idle", mode, 0);

        // R11 STOP and addr_done in the same cycle
        req_start = 1; req_rd = 1; step(); req_start = 0; req_rd = 0;
        chk("R7 master read open", mode, 2);
        bus_start();
        scl_in = 1'b0; step(3); sda_in = 1'b0; step(3); scl_in = 1'b1; step(3);
        sda_in = 1'b1; step(3);
        chk("R11 stop pulse aligned", stop_det, 1);
        addr_done = 1; req_byte = 1; step(); addr_done = 0; req_byte = 0;
        chk("R11 stop beats addr_done", mode, 0);
        chk("R11 no cmd", {cmd_start, cmd_stop, cmd_byte}, 0);

        // R11 STOP and start request in the same cycle, then retry
        bus_start();
        scl_in = 1'b0; step(3); sda_in = 1'b0; step(3); scl_in = 1'b1; step(3);
        sda_in = 1'b1; step(3);
        chk("R11 stop pulse aligned 2", stop_det, 1);
        req_start = 1; step();
        chk("R11 request refused", {mode, cmd_start}, 0);
        step(); req_start = 0;
        chk("R7 retry accepted", mode, 2);
        chk("R7 retry cmd_start", cmd_start, 1);

        step(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule